// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a synchronous binary counter that steps up or down and wraps at its width. On each rising clock edge it either takes a preset value or steps in the selected direction or holds. Each of these is set by active-low controls. It has no reset input, so a user starts it with a load.

Counting needs two active-low enables. One is a local enable. The other is a chain enable that also gates the terminal-count flag. The flag is active low and purely combinational. It goes low when the chain enable is low and the state sits at its top value while counting up, or at zero while counting down. The flag of one stage feeds the chain enable of the next stage, and all stages share the local enable, the load and the direction. Several stages joined this way form one wider counter with carry lookahead.

Top module: `updown_counter`

## Requirements
- R1: The state changes only on a rising clock edge. Between edges `count_q` is stable.
- R2: With `load_n` low, `count_q` takes `preset_d` at the next edge, whatever the enables and the direction are.
- R3: With `load_n` high and both `en_local_n` and `en_chain_n` low, `count_q` moves one step at the edge, upward when `up_dn` is 1 and downward when it is 0.
- R4: With `load_n` high and either enable high, `count_q` holds.
- R5: Counting wraps modulo 2^WIDTH. In the default 4-bit build, 15 goes to 0 counting up and 0 goes to 15 counting down.
- R6: `tc_n` is 0 exactly when `en_chain_n` is 0 and either `up_dn`=1 with the state all ones, or `up_dn`=0 with the state zero. Otherwise it is 1. `en_local_n` has no effect on it.
- R7: `tc_n` follows changes of `up_dn` and `en_chain_n` with no clock edge in between.
- R8: Two stages chained tc_n to en_chain_n, sharing load, local enable and direction, count modulo 256 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Active-low synchronous preset |
| en_local_n | input | 1 | Active-low local count enable |
| en_chain_n | input | 1 | Active-low chain count enable, also gates tc_n |
| up_dn | input | 1 | 1 counts up, 0 counts down |
| preset_d | input | WIDTH | Value taken on load |
| count_q | output | WIDTH | Counter state |
| tc_n | output | 1 | Active-low terminal count |

## Verification
The bench builds the counter with the default WIDTH of 4. This keeps both wrap points, 15 and 0, a few steps from any loaded value, so direction reversals right at these points can be forced directly. It also builds a two-stage chain of the same 4-bit counter, whose 8-bit result is checked against a modulo-256 model. That covers carries and borrows crossing the stage boundary, including 0x0F to 0x10 and 0x00 to 0xFF.

// File: rtl/updown_counter.sv
module updown_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             en_local_n,
  input  logic             en_chain_n,
  input  logic             up_dn,
  input  logic [WIDTH-1:0] preset_d,
  output logic [WIDTH-1:0] count_q,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic step;
  assign step = load_n & ~en_local_n & ~en_chain_n;

  always_ff @(posedge clk) begin
    if (!load_n)   count_q <= preset_d;
    else if (step) count_q <= up_dn ? count_q + 1'b1 : count_q - 1'b1;
  end

  logic at_end;
  assign at_end = up_dn ? (count_q == TOP) : (count_q == '0);
  assign tc_n   = ~(at_end & ~en_chain_n);

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  assert_load_R2: assert property (@(posedge clk) disable iff (!primed)
    !load_n |=> count_q == $past(preset_d));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!primed)
    (load_n && (en_local_n || en_chain_n)) |=> $stable(count_q));
  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!primed)
    (load_n && !en_local_n && !en_chain_n && up_dn && count_q == TOP) |=> count_q == '0);
  assert_wrap_dn_R5: assert property (@(posedge clk) disable iff (!primed)
    (load_n && !en_local_n && !en_chain_n && !up_dn && count_q == '0) |=> count_q == TOP);
  assert_tc_gate_R6: assert property (@(posedge clk) disable iff (!primed)
    en_chain_n |-> tc_n);
endmodule

// File: tb/updown_counter_tb.sv
module updown_counter_tb;
  logic clk = 0;
  always #10 clk = ~clk;

  logic load_n = 0, en_l = 1, en_c = 1, up = 1;
  logic [3:0] d = 0;
  logic [3:0] q;
  logic tc;
  int checks = 0, fails = 0;

  updown_counter #(.WIDTH(4)) u_dut (.clk(clk), .load_n(load_n), .en_local_n(en_l),
    .en_chain_n(en_c), .up_dn(up), .preset_d(d), .count_q(q), .tc_n(tc));

  logic [3:0] lo_q, hi_q, cd;
  logic lo_tc, hi_tc;
  updown_counter #(.WIDTH(4)) u_lo (.clk(clk), .load_n(load_n), .en_local_n(en_l),
    .en_chain_n(en_c), .up_dn(up), .preset_d(cd), .count_q(lo_q), .tc_n(lo_tc));
  updown_counter #(.WIDTH(4)) u_hi (.clk(clk), .load_n(load_n), .en_local_n(en_l),
    .en_chain_n(lo_tc), .up_dn(up), .preset_d(cd), .count_q(hi_q), .tc_n(hi_tc));
  assign cd = 4'h0;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #5; endtask
  task automatic load(logic [3:0] v);
    load_n = 0; d = v; tick(); load_n = 1;
  endtask
  function automatic logic exp_tc(logic [3:0] s, logic u, logic c);
    return !(!c && (u ? s == 4'hF : s == 4'h0));
  endfunction

  task automatic t_load();
    en_l = 0; en_c = 0; up = 0; load(4'hA); chk("R2", q, 10);
    en_l = 1; en_c = 1; load(4'h3); chk("R2", q, 3);
  endtask

  task automatic t_count();
    logic [3:0] m;
    load(4'h5); m = 5; en_l = 0; en_c = 0;
    for (int i = 0; i < 20; i++) begin
      up = (i % 7) < 4; tick(); m = up ? m + 1 : m - 1; chk("R3", q, m);
    end
    en_l = 1; tick(); chk("R4", q, m);
    en_l = 0; en_c = 1; tick(); chk("R4", q, m);
    en_c = 0; @(negedge clk); up = ~up; #3; chk("R1", q, m);
  endtask

  task automatic t_wrap();
    en_l = 0; en_c = 0; up = 1; load(4'hF); tick(); chk("R5", q, 0);
    up = 0; tick(); chk("R5", q, 15);
    up = 1; tick(); chk("R5", q, 0);
  endtask

  task automatic t_tc();
    en_l = 1;
    for (int s = 0; s < 16; s += 15) begin
      load(4'(s));
      for (int k = 0; k < 8; k++) begin
        up = k[0]; en_c = k[1]; en_l = k[2]; #1;
        chk("R6", tc, exp_tc(4'(s), up, en_c));
      end
    end
    en_l = 1; load(4'h0); en_c = 0; up = 0; #1; chk("R7", tc, 0);
    up = 1; #1; chk("R7", tc, 1);
    up = 0; en_c = 1; #1; chk("R7", tc, 1);
  endtask

  task automatic t_chain();
    logic [7:0] m;
    en_l = 1; en_c = 0; load(4'h0); m = 0; en_l = 0;
    up = 1;
    for (int i = 0; i < 300; i++) begin
      tick(); m++; if (i % 37 == 0) chk("R8", {hi_q, lo_q}, m);
    end
    chk("R8", {hi_q, lo_q}, m);
    up = 0;
    for (int i = 0; i < 300; i++) begin
      tick(); m--; if (i % 41 == 0) chk("R8", {hi_q, lo_q}, m);
    end
    chk("R8", {hi_q, lo_q}, m);
  endtask

  initial begin
    fork
      begin
        tick(); load_n = 1; #1;
        t_load(); t_count(); t_wrap(); t_tc(); t_chain();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++; $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule